// File: doc/BRIEF.md
# Command FIFO Interrupt Controller

This block raises one interrupt line for a graphics command queue. It watches four conditions. The first is the queue's occupancy count reaching a programmable threshold. The second is the queue-full indication. The last two are pulses from the rendering engine: one when the current command completes and one when every queued command has completed. Each condition latches a sticky pending flag. Software clears a flag by writing 1 to it. The interrupt output is asserted while any pending flag that also has its enable bit set is 1.

Software reaches the block through a small word-addressed register port with a combinational read path. There are four registers:

| Index | Register | Access |
|-------|----------|--------|
| 0 | Source enables | read/write |
| 1 | Occupancy threshold | read/write |
| 2 | Pending flags | write-1-to-clear |
| 3 | Engine status | read-only |

The status register has two bits:
- An "idle after the current command" bit.
- An "idle after all commands" bit.

The engine uses these to report whether it is still rendering.

Top module: `cmdfifo_irq`

## Requirements
- R1: After reset the registers read as follows: enables 0x0, threshold 0x18, pending 0x8000_0000 and status 0x600. The interrupt output is 0.
- R2: Threshold register (index 1) bits [5:0] hold the threshold and are writable. Bits [31:6] read as 0 whatever was written.
- R3: Pending bit 0 is the occupancy flag. It sets in the cycle after the comparison "used count >= threshold" goes from false to true. It is not set again while the comparison stays true, and it sets again after the comparison falls and rises.
- R4: Pending bit 8 sets in the cycle after the full input is high. A write-1 clear made while full stays high leaves the bit at 1.
- R5: A current-command-done pulse sets pending bit 10. An all-commands-done pulse sets pending bit 9.
- R6: Writing 1 to a defined pending bit clears it. Writing 0 to a bit leaves it unchanged.
- R7: When a source sets a flag in the same cycle that a write-1 clear targets that flag, the flag ends at 1.
- R8: The enable register (index 0) uses the pending layout: bit 10, bit 9, bit 8 and bit 0. The interrupt output is 1 exactly when some pending bit and its matching enable bit are both 1.
- R9: Pending bit 31 always reads 1. Every other undefined bit of the enable and pending registers reads 0 and ignores writes.
- R10: Status register (index 3) bit 10 sets on a current-done pulse. Bit 9 sets on an all-done pulse. Both clear in the cycle after the used count falls below its previous value, and that clear wins over a done pulse in the same cycle. All other status bits read 0, and writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regAddr | input | 2 | Register word index |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Combinational read data for regAddr |
| fifoUsed | input | CNT_W | Command queue occupancy |
| fifoFull | input | 1 | Command queue full |
| curCmdDone | input | 1 | One-cycle pulse: current command finished |
| allCmdDone | input | 1 | One-cycle pulse: all commands finished |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle. A flag can be set by its source while the flag is being cleared by a software write-1. A status idle bit can be set by a done pulse while the queue count drops, which is read as the engine fetching its next command. The bench provokes the first case by driving a current-done pulse on the same clock as a write-1 to pending bit 10. It also holds full high across a clear of bit 8. It provokes the second case by lowering the used count on the same clock as a current-done pulse. The set must win in the pending register, and the fetch must win in the status register. Each outcome is judged by reading the register back on the next cycle.

// File: rtl/cmdfifo_irq_pkg.sv
package cmdfifo_irq_pkg;
  localparam int ADDR_W  = 2;
  localparam int SRC_N   = 4;
  localparam int POS_LVL = 0;
  localparam int POS_FULL = 8;
  localparam int POS_ALL = 9;
  localparam int POS_CUR = 10;
  localparam int POS_STICKY = 31;

  typedef enum logic [ADDR_W-1:0] {
    REG_EN   = 2'd0,
    REG_THR  = 2'd1,
    REG_PEND = 2'd2,
    REG_STAT = 2'd3
  } regSelE;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEnable;
    logic wrThresh;
    logic wrPend;
    logic setLvl;
    logic setFull;
    logic setAll;
    logic setCur;
    logic fetch;
  } strobeT;

  // source index -> bit position in enable/pending words
  function automatic int srcPos(int idx);
    case (idx)
      0: return POS_LVL;
      1: return POS_FULL;
      2: return POS_ALL;
      default: return POS_CUR;
    endcase
  endfunction
endpackage

// File: rtl/cmdfifo_irq_ctrl.sv
module cmdfifo_irq_ctrl
  import cmdfifo_irq_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int THR_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [CNT_W-1:0]    usedCnt,
  input  logic                fifoFull,
  input  logic                curDone,
  input  logic                allDone,
  input  logic [THR_W-1:0]    thrIn,
  output strobeT              stb,
  output regSelE              rdSel
);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CMP_W-1:0] usedExt;
  logic [CMP_W-1:0] thrExt;
  logic             atLevel;
  logic             atLevelQ;
  logic [CNT_W-1:0] prevUsedQ;

  assign usedExt = CMP_W'(usedCnt);
  assign thrExt  = CMP_W'(thrIn);
  assign atLevel = (usedExt >= thrExt);
  assign rdSel   = regSelE'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      atLevelQ  <= 1'b0;
      prevUsedQ <= '0;
    end else begin
      atLevelQ  <= atLevel;
      prevUsedQ <= usedCnt;
    end
  end

  always_comb begin
    stb          = '0;
    stb.wrEnable = wrEn && (rdSel == REG_EN);
    stb.wrThresh = wrEn && (rdSel == REG_THR);
    stb.wrPend   = wrEn && (rdSel == REG_PEND);
    stb.setLvl   = atLevel && !atLevelQ;
    stb.setFull  = fifoFull;
    stb.setAll   = allDone;
    stb.setCur   = curDone;
    stb.fetch    = (usedCnt < prevUsedQ);
  end
endmodule

// File: rtl/cmdfifo_irq_datapath.sv
module cmdfifo_irq_datapath
  import cmdfifo_irq_pkg::*;
#(
  parameter int              DATA_W  = 32,
  parameter int              THR_W   = 6,
  parameter logic [THR_W-1:0] THR_RST = 6'h18
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            stb,
  input  regSelE            rdSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [THR_W-1:0]  thrOut,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  logic [SRC_N-1:0] pendQ;
  logic [SRC_N-1:0] enQ;
  logic [SRC_N-1:0] setVec;
  logic [THR_W-1:0] thrQ;
  logic             curIdleQ;
  logic             allIdleQ;
  logic [DATA_W-1:0] pendWord;
  logic [DATA_W-1:0] enWord;
  logic [DATA_W-1:0] statWord;

  assign setVec = {stb.setCur, stb.setAll, stb.setFull, stb.setLvl};

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    localparam int P = srcPos(i);
    always_ff @(posedge clk) begin
      if (rst) begin
        pendQ[i] <= 1'b0;
        enQ[i]   <= 1'b0;
      end else begin
        if (setVec[i])
          pendQ[i] <= 1'b1;
        else if (stb.wrPend && wrData[P])
          pendQ[i] <= 1'b0;
        if (stb.wrEnable)
          enQ[i] <= wrData[P];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thrQ     <= THR_RST;
      curIdleQ <= 1'b1;
      allIdleQ <= 1'b1;
    end else begin
      if (stb.wrThresh)
        thrQ <= wrData[THR_W-1:0];
      if (stb.fetch)
        curIdleQ <= 1'b0;
      else if (stb.setCur)
        curIdleQ <= 1'b1;
      if (stb.fetch)
        allIdleQ <= 1'b0;
      else if (stb.setAll)
        allIdleQ <= 1'b1;
    end
  end

  always_comb begin
    pendWord = '0;
    enWord   = '0;
    for (int i = 0; i < SRC_N; i++) begin
      pendWord[srcPos(i)] = pendQ[i];
      enWord[srcPos(i)]   = enQ[i];
    end
    pendWord[POS_STICKY] = 1'b1;
    statWord = '0;
    statWord[POS_CUR] = curIdleQ;
    statWord[POS_ALL] = allIdleQ;
  end

  always_comb begin
    case (rdSel)
      REG_EN:   rdData = enWord;
      REG_THR:  rdData = DATA_W'(thrQ);
      REG_PEND: rdData = pendWord;
      default:  rdData = statWord;
    endcase
  end

  assign thrOut = thrQ;
  assign irq    = |(pendQ & enQ);
endmodule

// File: rtl/cmdfifo_irq.sv
module cmdfifo_irq
  import cmdfifo_irq_pkg::*;
#(
  parameter int               DATA_W  = 32,
  parameter int               CNT_W   = 7,
  parameter int               THR_W   = 6,
  parameter logic [THR_W-1:0] THR_RST = 6'h18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [CNT_W-1:0]  fifoUsed,
  input  logic              fifoFull,
  input  logic              curCmdDone,
  input  logic              allCmdDone,
  output logic              irq
);
  strobeT           stb;
  regSelE           rdSel;
  logic [THR_W-1:0] thrVal;

  cmdfifo_irq_ctrl #(.CNT_W(CNT_W), .THR_W(THR_W)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(regWrEn), .addr(regAddr),
    .usedCnt(fifoUsed), .fifoFull(fifoFull), .curDone(curCmdDone),
    .allDone(allCmdDone), .thrIn(thrVal), .stb(stb), .rdSel(rdSel)
  );

  cmdfifo_irq_datapath #(.DATA_W(DATA_W), .THR_W(THR_W), .THR_RST(THR_RST)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .rdSel(rdSel), .wrData(regWrData),
    .thrOut(thrVal), .rdData(regRdData), .irq(irq)
  );
endmodule

// File: rtl/cmdfifo_irq_chk.sv
module cmdfifo_irq_chk #(
  parameter int DATA_W = 32,
  parameter int THR_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regRdData,
  input logic              fifoFull,
  input logic              curCmdDone,
  input logic              allCmdDone,
  input logic              irq
);
  p_sticky_top_r9: assert property (@(posedge clk) disable iff (rst)
    (regAddr == 2'd2) |-> regRdData[31]);

  p_thr_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (regAddr == 2'd1) |-> ((regRdData >> THR_W) == '0));

  p_stat_reserved_r10: assert property (@(posedge clk) disable iff (rst)
    (regAddr == 2'd3) |-> ((regRdData & ~DATA_W'(32'h600)) == '0));

  p_cur_sets_r5: assert property (@(posedge clk) disable iff (rst)
    curCmdDone |=> (regAddr != 2'd2 || regRdData[10]));

  p_all_sets_r5: assert property (@(posedge clk) disable iff (rst)
    allCmdDone |=> (regAddr != 2'd2 || regRdData[9]));

  p_full_sets_r4: assert property (@(posedge clk) disable iff (rst)
    fifoFull |=> (regAddr != 2'd2 || regRdData[8]));

  p_irq_drop_by_write_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> ($past(regWrEn) || $past(rst)));
endmodule

bind cmdfifo_irq cmdfifo_irq_chk #(.DATA_W(DATA_W), .THR_W(THR_W)) u_chk (.*);

// File: tb/cmdfifo_irq_tb.sv
module cmdfifo_irq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [6:0]  fifoUsed = '0;
  logic        fifoFull = 1'b0;
  logic        curCmdDone = 1'b0;
  logic        allCmdDone = 1'b0;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  cmdfifo_irq u_dut (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .fifoUsed(fifoUsed),
    .fifoFull(fifoFull), .curCmdDone(curCmdDone), .allCmdDone(allCmdDone),
    .irq(irq)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic setUsed(logic [6:0] v);
    @(negedge clk);
    fifoUsed = v;
    @(negedge clk);
  endtask

  task automatic pulseCur();
    @(negedge clk); curCmdDone = 1'b1;
    @(negedge clk); curCmdDone = 1'b0;
  endtask

  task automatic pulseAll();
    @(negedge clk); allCmdDone = 1'b1;
    @(negedge clk); allCmdDone = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); check("R1 enable reset", d, 32'h0);
    rd(2'd1, d); check("R1 threshold reset", d, 32'h18);
    rd(2'd2, d); check("R1 R9 pending reset", d, 32'h8000_0000);
    rd(2'd3, d); check("R1 status reset", d, 32'h600);
    check("R1 irq reset", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_thresh();
    logic [31:0] d;
    wr(2'd1, 32'hFFFF_FFC5);
    rd(2'd1, d); check("R2 threshold field only", d, 32'h05);
    wr(2'd2, 32'h7FFF_F8FE);
    rd(2'd2, d); check("R9 reserved pending bits", d, 32'h8000_0000);
  endtask

  task automatic t_level();
    logic [31:0] d;
    setUsed(7'd4);
    rd(2'd2, d); check("R3 below level", d & 32'h1, 32'h0);
    setUsed(7'd5);
    rd(2'd2, d); check("R3 level reached", d & 32'h1, 32'h1);
    wr(2'd2, 32'h1);
    rd(2'd2, d); check("R6 level cleared", d & 32'h1, 32'h0);
    setUsed(7'd6);
    rd(2'd2, d); check("R3 no reset while above", d & 32'h1, 32'h0);
    setUsed(7'd3);
    setUsed(7'd5);
    rd(2'd2, d); check("R3 re-arm after falling", d & 32'h1, 32'h1);
    wr(2'd2, 32'h1);
    setUsed(7'd0);
  endtask

  task automatic t_full();
    logic [31:0] d;
    @(negedge clk); fifoFull = 1'b1;
    @(negedge clk);
    rd(2'd2, d); check("R4 full sets", d & 32'h100, 32'h100);
    wr(2'd2, 32'h100);
    rd(2'd2, d); check("R4 clear while full", d & 32'h100, 32'h100);
    @(negedge clk); fifoFull = 1'b0;
    wr(2'd2, 32'h100);
    rd(2'd2, d); check("R6 full cleared", d & 32'h100, 32'h0);
  endtask

  task automatic t_done();
    logic [31:0] d;
    pulseCur();
    rd(2'd2, d); check("R5 cur sets bit10", d & 32'h600, 32'h400);
    pulseAll();
    rd(2'd2, d); check("R5 all sets bit9", d & 32'h600, 32'h600);
    wr(2'd2, 32'h200);
    rd(2'd2, d); check("R6 write0 keeps bit10", d, 32'h8000_0400);
    wr(2'd2, 32'h400);
    rd(2'd2, d); check("R6 bit10 cleared", d, 32'h8000_0000);
  endtask

  task automatic t_setwins();
    logic [31:0] d;
    pulseCur();
    @(negedge clk);
    regAddr = 2'd2; regWrData = 32'h400; regWrEn = 1'b1; curCmdDone = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; curCmdDone = 1'b0;
    rd(2'd2, d); check("R7 set wins over clear", d & 32'h400, 32'h400);
    wr(2'd2, 32'h400);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    pulseCur();
    check("R8 disabled source no irq", {31'd0, irq}, 32'h0);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R9 enable reserved bits", d, 32'h701);
    check("R8 enabled source irq", {31'd0, irq}, 32'h1);
    wr(2'd0, 32'h1);
    check("R8 other enable only", {31'd0, irq}, 32'h0);
    wr(2'd0, 32'h400);
    check("R8 re-enabled", {31'd0, irq}, 32'h1);
    wr(2'd2, 32'h400);
    check("R8 cleared drops irq", {31'd0, irq}, 32'h0);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    setUsed(7'd5);
    setUsed(7'd2);
    rd(2'd3, d); check("R10 fetch clears status", d, 32'h0);
    pulseCur();
    rd(2'd3, d); check("R10 cur idle", d, 32'h400);
    pulseAll();
    rd(2'd3, d); check("R10 all idle", d, 32'h600);
    wr(2'd3, 32'h0);
    rd(2'd3, d); check("R10 write ignored", d, 32'h600);
    @(negedge clk);
    fifoUsed = 7'd1; curCmdDone = 1'b1;
    @(negedge clk);
    curCmdDone = 1'b0;
    rd(2'd3, d); check("R10 fetch wins over done", d, 32'h0);
    setUsed(7'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_thresh();
    t_level();
    t_full();
    t_done();
    t_setwins();
    t_irq();
    t_status();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule